// File: doc/BRIEF.md
# Transmit Overhead Insertion Port

This block sits in the transmit path of a serial framer and lets external terminal equipment overwrite selected overhead bits of each outgoing frame. It keeps its own bit-position counter and a fixed frame schedule. The schedule labels every position as payload, insertable overhead or protected overhead. For each position the block emits one serial bit. Payload positions carry the payload input. Overhead positions carry either the framer's internally generated value or a bit offered by the terminal equipment.

The handshake looks one bit ahead. During the clock cycle just before an overhead bit goes out, the block raises an enable strobe and an overhead clock pulse. The terminal equipment sees the strobe on the falling edge and answers with a data bit and an insert request. The block captures both on the next rising edge. The offered bit replaces the internal value only on insertable positions. On protected positions the request is dropped silently. The strobe and clock pulse are still produced for protected positions.

Top module: `txoh_insert`

## Requirements
- R1: Synchronous active-high reset drives `ser_out`, `oh_en` and `oh_clk` low and returns the bit counter to position 0. The first bit sent after reset is position 0, and no enable strobe precedes it.
- R2: Position p is overhead when p mod OH_STRIDE is 0, otherwise payload. Overhead position p is protected when (p / OH_STRIDE) mod PROT_EVERY is 0, otherwise insertable. With the defaults (24, 4, 3), positions 0 and 12 are protected and 4, 8, 16 and 20 are insertable. The counter wraps from FRAME_LEN-1 to 0.
- R3: `oh_en` is high for exactly one clock cycle, the cycle immediately before each overhead bit appears on `ser_out`, and is low in every other cycle. This holds for protected overhead bits as well as insertable ones.
- R4: `oh_clk` rises at the start of that same cycle and falls at its end, where the offered data is captured. It pulses once for every overhead bit, protected ones included, and stays low around payload bits.
- R5: If `oh_ins` is high at the rising edge that ends an enable cycle for an insertable position, the `oh_data` value captured at that edge is sent for that position.
- R6: If `oh_ins` is low at that edge, the `dflt_bit` value captured at that edge is sent and `oh_data` has no effect.
- R7: On a protected position, `dflt_bit` is sent whatever `oh_ins` and `oh_data` are. The drop is not signalled.
- R8: On a payload position, `pay_bit` is sent unchanged, and `oh_ins` and `oh_data` have no effect.
- R9: The inputs for a position are captured at the rising edge that ends the position's input cycle. `ser_out` shows the resulting bit from that edge until the next one, so the latency is one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous active-high reset |
| pay_bit | input | 1 | Payload bit for the current position |
| dflt_bit | input | 1 | Internally generated overhead value for the current position |
| oh_ins | input | 1 | Insert request from terminal equipment |
| oh_data | input | 1 | Overhead bit offered by terminal equipment |
| oh_en | output | 1 | One-cycle look-ahead strobe before each overhead bit |
| oh_clk | output | 1 | Overhead clock; falling edge marks the capture instant |
| ser_out | output | 1 | Final serial bit |

## Verification
A counter that slips or fails to wrap moves every enable pulse away from the schedule. The strobe check sees the misplacement one cycle before the affected bit would go out, and the payload and overhead substitutions are misrouted at the same time. A wrong slot label shows as an offered bit leaking onto a protected position, or as a default appearing where an accepted insert was expected. A one-cycle offset between the strobe and the output register shows as a captured bit landing on its neighbour position on the very next edge.

// File: rtl/txoh_pkg.sv
package txoh_pkg;

  typedef enum logic [1:0] {
    SLOT_PAY  = 2'd0,
    SLOT_INS  = 2'd1,
    SLOT_PROT = 2'd2
  } slot_e;

  // Frame schedule rule: overhead every 'stride' bits, every 'prot_every'-th
  // overhead slot (starting at the first) cannot be overwritten.
  function automatic slot_e slot_of(input int p, input int stride, input int prot_every);
    if ((p % stride) != 0)                  return SLOT_PAY;
    if (((p / stride) % prot_every) == 0)   return SLOT_PROT;
    return SLOT_INS;
  endfunction

endpackage

// File: rtl/txoh_sched.sv
module txoh_sched
  import txoh_pkg::*;
#(
  parameter int FRAME_LEN  = 24,
  parameter int OH_STRIDE  = 4,
  parameter int PROT_EVERY = 3
) (
  input  logic  clk,
  input  logic  rst,
  output slot_e cur_kind,
  output slot_e next_kind
);
  localparam int POS_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  slot_e            kind_rom [FRAME_LEN];
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] pos_nxt;

  // Constant schedule table built at elaboration
  for (genvar i = 0; i < FRAME_LEN; i++) begin : g_rom
    assign kind_rom[i] = slot_of(i, OH_STRIDE, PROT_EVERY);
  end

  assign pos_nxt = (pos == LAST_POS) ? '0 : pos + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) pos <= '0;
    else     pos <= pos_nxt;
  end

  assign cur_kind  = kind_rom[pos];
  assign next_kind = kind_rom[pos_nxt];

  AST_POS_WRAP: assert property (@(posedge clk) disable iff (rst)
    (pos == LAST_POS) |=> (pos == '0)); // R2
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    pos <= LAST_POS); // R2

endmodule

// File: rtl/txoh_strobe.sv
module txoh_strobe
  import txoh_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  slot_e cur_kind,
  input  slot_e next_kind,
  output logic  oh_en,
  output logic  oh_clk
);

  always_ff @(posedge clk) begin
    if (rst) begin
      oh_en  <= 1'b0;
      oh_clk <= 1'b0;
    end else begin
      oh_en  <= (next_kind != SLOT_PAY);
      oh_clk <= (next_kind != SLOT_PAY);
    end
  end

  AST_EN_SINGLE: assert property (@(posedge clk) disable iff (rst)
    oh_en |=> !oh_en); // R3
  AST_EN_ON_OH: assert property (@(posedge clk) disable iff (rst)
    oh_en |-> (cur_kind != SLOT_PAY)); // R3
  AST_CLK_WITH_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(oh_clk) |-> oh_en); // R4
  AST_CLK_LOW_PAY: assert property (@(posedge clk) disable iff (rst)
    (cur_kind == SLOT_PAY) |-> !oh_clk); // R4

endmodule

// File: rtl/txoh_mux.sv
module txoh_mux
  import txoh_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  slot_e cur_kind,
  input  logic  oh_en,
  input  logic  pay_bit,
  input  logic  dflt_bit,
  input  logic  oh_ins,
  input  logic  oh_data,
  output logic  ser_out
);
  logic take;

  // Insert honoured only after the strobe was offered, on an insertable slot
  assign take = oh_en && (cur_kind == SLOT_INS) && oh_ins;

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_out <= 1'b0;
    end else begin
      case (cur_kind)
        SLOT_PAY: ser_out <= pay_bit;
        SLOT_INS: ser_out <= take ? oh_data : dflt_bit;
        default:  ser_out <= dflt_bit;
      endcase
    end
  end

  AST_INS_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (oh_en && cur_kind == SLOT_INS && oh_ins) |=> (ser_out == $past(oh_data))); // R5
  AST_NO_REQ_DFLT: assert property (@(posedge clk) disable iff (rst)
    (cur_kind != SLOT_PAY && !oh_ins) |=> (ser_out == $past(dflt_bit))); // R6
  AST_PROT_DFLT: assert property (@(posedge clk) disable iff (rst)
    (cur_kind == SLOT_PROT) |=> (ser_out == $past(dflt_bit))); // R7
  AST_PAY_PASS: assert property (@(posedge clk) disable iff (rst)
    (cur_kind == SLOT_PAY) |=> (ser_out == $past(pay_bit))); // R8

endmodule

// File: rtl/txoh_insert.sv
module txoh_insert
  import txoh_pkg::*;
#(
  parameter int FRAME_LEN  = 24,
  parameter int OH_STRIDE  = 4,
  parameter int PROT_EVERY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pay_bit,
  input  logic dflt_bit,
  input  logic oh_ins,
  input  logic oh_data,
  output logic oh_en,
  output logic oh_clk,
  output logic ser_out
);
  slot_e cur_kind;
  slot_e next_kind;

  txoh_sched #(
    .FRAME_LEN (FRAME_LEN),
    .OH_STRIDE (OH_STRIDE),
    .PROT_EVERY(PROT_EVERY)
  ) u_sched (
    .clk      (clk),
    .rst      (rst),
    .cur_kind (cur_kind),
    .next_kind(next_kind)
  );

  txoh_strobe u_strobe (
    .clk      (clk),
    .rst      (rst),
    .cur_kind (cur_kind),
    .next_kind(next_kind),
    .oh_en    (oh_en),
    .oh_clk   (oh_clk)
  );

  txoh_mux u_mux (
    .clk     (clk),
    .rst     (rst),
    .cur_kind(cur_kind),
    .oh_en   (oh_en),
    .pay_bit (pay_bit),
    .dflt_bit(dflt_bit),
    .oh_ins  (oh_ins),
    .oh_data (oh_data),
    .ser_out (ser_out)
  );

  AST_RST_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!oh_en && !oh_clk && !ser_out)); // R1

endmodule

// File: tb/txoh_insert_test.sv
module txoh_insert_test;
  localparam int FL = 24;
  localparam int ST = 4;
  localparam int PE = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pay_bit = 1'b0, dflt_bit = 1'b0, oh_ins = 1'b0, oh_data = 1'b0;
  logic oh_en, oh_clk, ser_out;

  typedef struct {
    logic  val;
    string req;
    int    pos;
  } exp_t;

  exp_t q[$];
  int n_run = 0;
  int n_fail = 0;
  int pos_tb = 0;
  bit first = 1'b1;

  always #4 clk = ~clk;  // 125 MHz

  txoh_insert #(.FRAME_LEN(FL), .OH_STRIDE(ST), .PROT_EVERY(PE)) uut (
    .clk(clk), .rst(rst), .pay_bit(pay_bit), .dflt_bit(dflt_bit),
    .oh_ins(oh_ins), .oh_data(oh_data),
    .oh_en(oh_en), .oh_clk(oh_clk), .ser_out(ser_out)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // 0 payload, 1 insertable, 2 protected (schedule rule from R2)
  function automatic int kind_of(input int p);
    if (p % ST != 0) return 0;
    if (((p / ST) % PE) == 0) return 2;
    return 1;
  endfunction

  // Monitor: pop and compare one result per edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.req, $sformatf("ser_out pos %0d", e.pos), ser_out, e.val);
    end
  end

  // Driver: one position per call, entered and left at a falling edge
  task automatic drive_pos(input int mode);
    int   k;
    logic en_exp;
    exp_t e;
    k = kind_of(pos_tb);
    en_exp = first ? 1'b0 : (k != 0);
    chk(first ? "R1" : ((pos_tb == 0) ? "R2" : "R3"),
        $sformatf("oh_en pos %0d", pos_tb), oh_en, en_exp);
    chk("R4", $sformatf("oh_clk pos %0d", pos_tb), oh_clk, en_exp);
    pay_bit  = 1'($urandom);
    dflt_bit = 1'($urandom);
    oh_data  = 1'($urandom);
    case (mode)
      1:       oh_ins = 1'b1;
      2:       oh_ins = 1'b0;
      default: oh_ins = 1'($urandom);
    endcase
    e.pos = pos_tb;
    if (k == 0) begin
      e.val = pay_bit;  e.req = "R8 R9";
    end else if (k == 2) begin
      e.val = dflt_bit; e.req = "R7";
    end else if (oh_ins && en_exp) begin
      e.val = oh_data;  e.req = "R5 R9";
    end else begin
      e.val = dflt_bit; e.req = "R6";
    end
    q.push_back(e);
    pos_tb = (pos_tb + 1) % FL;
    first = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(input int cycles, input int mode);
    for (int i = 0; i < cycles; i++) drive_pos(mode);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    oh_ins = 1'b1; oh_data = 1'b1; pay_bit = 1'b1; dflt_bit = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R1", "ser_out in reset", ser_out, 1'b0);
      chk("R1", "oh_en in reset", oh_en, 1'b0);
      chk("R1", "oh_clk in reset", oh_clk, 1'b0);
    end
    rst = 1'b0;
    pos_tb = 0;
    first = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    run(2 * FL, 0);
    run(FL, 1);        // always request: insertable take, protected drop
    run(FL, 2);        // never request: defaults everywhere
    run(13, 0);        // stop mid-frame
    do_reset();        // counter must restart at position 0
    run(2 * FL, 0);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule